// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every data beat of an SDRAM read or write burst. A column command (`start_i`) captures a start column, a burst length code and an ordering choice. From the next cycle on, the block shows one column per cycle on `col_o` and holds `active_o` high until the burst ends.

A burst ends in one of three ways: it reaches its programmed length, a burst-terminate arrives, or a precharge to the bank arrives. A new column command issued during a burst drops the old burst and starts over at the new column. Lengths of 1, 2, 4 and 8 beats stay inside the aligned block of that size. Beats are ordered either by counting upward with wrap (sequential) or by XOR with the beat index (interleaved). Full-page mode walks the whole row upward, wraps at the top and runs until it is stopped.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_ni` is low, `active_o` is 0 and `col_o` is 0.
- R2: In the cycle after a clock edge that samples `start_i` high, `active_o` is 1 and `col_o` equals the `col_i` sampled at that edge.
- R3: With `intl_i`=0 and a length of 2, 4 or 8 beats, beat k shows the start column's bits above the block unchanged, and low bits equal to (start low bits + k) modulo the burst length.
- R4: With `intl_i`=1 and a length of 2, 4 or 8 beats, beat k shows the start column's bits above the block unchanged, and low bits equal to start low bits XOR k.
- R5: `len_i` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. `active_o` is high for exactly that many cycles and then falls.
- R6: Any `len_i` code with bit 2 set selects full page. The column counts upward by one per cycle modulo 2^COL_W, `intl_i` is ignored, and the burst runs until it is stopped.
- R7: A `start_i` during an active burst abandons that burst. The next cycle shows beat 0 of the new burst.
- R8: `term_i` high with `start_i` low makes `active_o` 0 in the next cycle.
- R9: `pre_i` high with `start_i` low makes `active_o` 0 in the next cycle.
- R10: When `start_i` is high in the same cycle as `term_i` or `pre_i`, the new burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command (read or write) issued this cycle |
| col_i | input | COL_W | Start column of the new burst |
| len_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, bit 2 set: full page) |
| intl_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| term_i | input | 1 | Burst-terminate command |
| pre_i | input | 1 | Precharge to this bank |
| col_o | output | COL_W | Column of the current beat |
| active_o | output | 1 | A burst beat is presented this cycle |

## Verification
The bench builds the block with the default 9-bit column and the interleaved path enabled. A 9-bit column lets a full-page burst started near the top of the row be seen wrapping from 511 to 0 in a few cycles. It also lets 8-beat bursts start at columns whose upper bits are non-zero, so any leak from the low bits into the upper bits would change the output. Start, terminate and precharge arrive at several beat positions, and in one case in the same cycle, to check the order in which they take effect.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int LEN_W    = 3;
  localparam int FULL_BIT = 2;
  typedef enum logic {BT_SEQ = 1'b0, BT_INTL = 1'b1} btype_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             full_i,
  input  logic [COL_W-1:0] mask_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] beat_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q;

  assign last_o = active_q && !full_i && (beat_q == mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      else        beat_q   <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;

  AST_START_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o && (beat_o == '0)); // R2
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !active_o); // R8
  AST_LAST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !active_o); // R5
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W   = 9,
  parameter bit INTL_EN = 1'b1
) (
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             intl_i,
  input  logic [COL_W-1:0] beat_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_lo, low;

  assign seq_lo = start_col_i + beat_i;

  generate
    if (INTL_EN) begin : g_intl
      assign low = intl_i ? (start_col_i ^ beat_i) : seq_lo;
    end else begin : g_seq_only
      logic unused_intl;
      assign unused_intl = intl_i;
      assign low = seq_lo;
    end
  endgenerate

  // upper bits pinned to start column, lower bits wrap inside the block
  assign col_o = (start_col_i & ~mask_i) | (low & mask_i);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter bit INTL_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_i,
  input  logic             intl_i,
  input  logic             term_i,
  input  logic             pre_i,
  output logic [COL_W-1:0] col_o,
  output logic             active_o
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  logic [COL_W-1:0] start_q, mask_q, mask_d, beat;
  logic             full_q, last;
  btype_e           btype_q;

  always_comb begin
    if (len_i[FULL_BIT]) mask_d = ALL_ONES;
    else                 mask_d = COL_W'((1 << len_i[1:0]) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      btype_q <= BT_SEQ;
    end else if (start_i) begin
      start_q <= col_i;
      mask_q  <= mask_d;
      full_q  <= len_i[FULL_BIT];
      btype_q <= (intl_i && !len_i[FULL_BIT]) ? BT_INTL : BT_SEQ;
    end
  end

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (term_i | pre_i),
    .full_i   (full_q),
    .mask_i   (mask_q),
    .active_o (active_o),
    .last_o   (last),
    .beat_o   (beat)
  );

  burst_col_gen #(.COL_W(COL_W), .INTL_EN(INTL_EN)) u_gen (
    .start_col_i (start_q),
    .mask_i      (mask_q),
    .intl_i      (btype_q == BT_INTL),
    .beat_i      (beat),
    .col_o       (col_o)
  );

  AST_FIRST_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> col_o == $past(col_i)); // R2
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !last && !start_i && !term_i && !pre_i && btype_q == BT_SEQ)
    |=> ((col_o & mask_q) == (COL_W'($past(col_o) + 1'b1) & mask_q))
        && ((col_o & ~mask_q) == ($past(col_o) & ~mask_q))); // R3
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !active_o && col_o == '0); // R1
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  localparam int PERIOD = 10;
  localparam int COL_W  = 9;
  localparam int NCOL   = 1 << COL_W;

  typedef struct {
    bit    act;
    int    col;
    string tag;
  } item_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0]       len_i = '0;
  logic             intl_i = 1'b0;
  logic             term_i = 1'b0;
  logic             pre_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             active_o;

  item_t q[$];
  int  vec_cnt = 0;
  int  err_cnt = 0;
  bit  done = 1'b0;

  // reference model state
  bit m_act = 0, m_full = 0, m_il = 0;
  int m_base = 0, m_n = 1, m_beat = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .col_i(col_i),
    .len_i(len_i), .intl_i(intl_i), .term_i(term_i), .pre_i(pre_i),
    .col_o(col_o), .active_o(active_o)
  );

  function automatic int exp_col();
    int lo, hi;
    if (m_full) return (m_base + m_beat) % NCOL;
    hi = m_base - (m_base % m_n);
    lo = m_base % m_n;
    if (m_il) lo = lo ^ m_beat;
    else      lo = (lo + m_beat) % m_n;
    return hi + lo;
  endfunction

  task automatic step(input bit s, input int c, input int l, input bit il,
                      input bit t, input bit p, input string tag);
    item_t it;
    @(negedge clk_i);
    start_i = s; col_i = COL_W'(c); len_i = 3'(l); intl_i = il;
    term_i = t; pre_i = p;
    if (s) begin
      m_act = 1; m_base = c; m_full = (l >= 4);
      m_n = m_full ? NCOL : (1 << l); m_il = il && !m_full; m_beat = 0;
    end else if (t || p) begin
      m_act = 0;
    end else if (m_act) begin
      if (!m_full && m_beat == m_n - 1) m_act = 0;
      else m_beat = (m_beat + 1) % NCOL;
    end
    it.act = m_act; it.col = exp_col(); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      vec_cnt++;
      if (active_o !== e.act || (e.act && int'(col_o) != e.col)) begin
        err_cnt++;
        $display("FAIL %s: active=%0b col=%0d expected active=%0b col=%0d",
                 e.tag, active_o, col_o, e.act, e.col);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      err_cnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    vec_cnt++;
    if (active_o !== 1'b0 || col_o !== '0) begin
      err_cnt++;
      $display("FAIL R1: active=%0b col=%0d expected active=0 col=0", active_o, col_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 / R5: single beat
    step(1, 5, 0, 0, 0, 0, "R2"); idle(2, "R5");
    // R5: two beats
    step(1, 7, 1, 0, 0, 0, "R2"); idle(3, "R5");
    // R3: four beats, sequential wrap
    step(1, 13, 2, 0, 0, 0, "R3"); idle(5, "R3");
    // R3: eight beats, upper bits non-zero
    step(1, 501, 3, 0, 0, 0, "R3"); idle(9, "R3");
    // R4: interleaved eight and four
    step(1, 163, 3, 1, 0, 0, "R4"); idle(9, "R4");
    step(1, 290, 2, 1, 0, 0, "R4"); idle(5, "R4");
    // R6: full page wraps past the top, stopped by terminate (R8)
    step(1, 509, 4, 0, 0, 0, "R6"); idle(6, "R6");
    step(0, 0, 0, 0, 1, 0, "R8"); idle(2, "R8");
    // R6: full page code 7 ignores interleave, stopped by precharge (R9)
    step(1, 126, 7, 1, 0, 0, "R6"); idle(4, "R6");
    step(0, 0, 0, 0, 0, 1, "R9"); idle(2, "R9");
    // R7: restart mid burst
    step(1, 40, 3, 0, 0, 0, "R7"); idle(3, "R7");
    step(1, 77, 2, 1, 0, 0, "R7"); idle(5, "R7");
    // R8: terminate at beat 1 of eight
    step(1, 200, 3, 1, 0, 0, "R8"); idle(1, "R8");
    step(0, 0, 0, 0, 1, 0, "R8"); idle(2, "R8");
    // R9: precharge mid sequential burst
    step(1, 333, 3, 0, 0, 0, "R9"); idle(2, "R9");
    step(0, 0, 0, 0, 0, 1, "R9"); idle(2, "R9");
    // R10: start together with terminate and with precharge
    step(1, 60, 2, 0, 0, 0, "R10"); idle(1, "R10");
    step(1, 451, 2, 0, 1, 0, "R10"); idle(2, "R10");
    step(1, 98, 1, 1, 0, 1, "R10"); idle(3, "R10");

    repeat (3) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end
endmodule